// File: doc/BRIEF.md
# Output-Compare Timer Channel

A general-purpose 16-bit timer with one compare channel. A prescaler divides the clock, and the counter then steps up or down between zero and a reload value. On each count step the channel compares the counter with a compare register. From that result it produces a reference waveform. The waveform can be held, set, cleared or toggled on a match, forced to a fixed level, or generated as pulse-width modulation in either polarity.

Software configures the channel through a simple register port. Writes take one clock cycle. Reads are combinational. An enable bit and a two-bit direction field decide whether the reference waveform reaches the pin. A match sets a sticky flag, which can raise an interrupt. A match can also send a one-cycle DMA request.

Register map (address: content):

- 0 control: bit0 runs the counter, bit1 selects down-counting.
- 1 prescaler value.
- 2 reload value.
- 3 compare value.
- 4 channel: bits[1:0] direction (00 = output, 01, 10 and 11 = input), bits[4:2] compare mode, bit5 output enable.
- 5 request enables: bit0 interrupt, bit1 DMA.
- 6 status: bit0 is the match flag.
- 7 counter (read only).

Top module: `timer_oc_channel`

## Requirements
- R1: After reset every register reads 0, and `ocref_o`, `pin_o`, `irq_o` and `dma_req_o` are 0.
- R2: While control bit0 is 1, the counter takes one step every prescaler+1 clock cycles. While bit0 is 0, the counter holds its value.
- R3: Counting up (control bit1 = 0), the counter goes from 0 up to the reload value, and the next step takes it to 0.
- R4: Counting down (control bit1 = 1), the counter steps down to 0, and the next step loads the reload value.
- R5: A match is a count step that makes the counter equal to the compare value. A match sets status bit0, which stays set until a write to address 6 with bit0 = 0. Writing bit0 = 1 has no effect, and a match wins over a clear in the same cycle.
- R6: Mode 001 drives the reference high on a match, 010 drives it low, and 011 inverts it. Mode 000 keeps the reference unchanged, but matches still set the flag.
- R7: Mode 100 holds the reference low and mode 101 holds it high, whatever the counter value.
- R8: Mode 110 counting up: the reference is high while counter < compare. Counting down: it is high while counter <= compare.
- R9: Mode 111 gives the complement of mode 110 in both count directions.
- R10: `pin_o` follows the reference only when the output enable is 1 and the direction is 00. Otherwise it is 0.
- R11: A write to the direction bits is ignored while the output enable currently holds 1.
- R12: `irq_o` is the match flag ANDed with the interrupt enable. `dma_req_o` is high for exactly the cycle after each match edge, and only when the DMA enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| ocref_o | output | 1 | Reference waveform |
| pin_o | output | 1 | Gated channel output |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | One-cycle DMA request |

## Verification
The assertions assume that the reload and compare registers are rewritten only while the counter is stopped. The up-wrap and down-reload properties read the reload value across the step edge, so a rewrite at that edge would break them. The stimulus therefore changes the reload, compare and channel registers only after writing control bit0 to 0. The bench also accounts for the one count step that still happens on the same edge as the stop write. Input-direction codes are set only through the legal path, with the output enable cleared first.

// File: rtl/timer_oc_channel.sv
module timer_oc_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          ocref_o,
  output logic          pin_o,
  output logic          irq_o,
  output logic          dma_req_o
);

  localparam logic [2:0] A_CTRL = 3'd0, A_PSC = 3'd1, A_RLD = 3'd2, A_CMP = 3'd3,
                         A_CH = 3'd4, A_REQ = 3'd5, A_STAT = 3'd6, A_CNT = 3'd7;

  typedef enum logic [2:0] {
    M_FROZEN, M_SET, M_CLR, M_TGL, M_LOW, M_HIGH, M_PWM1, M_PWM2
  } mode_t;

  logic          run_q, down_q, oen_q, irqen_q, dmaen_q, flag_q, ocq, dma_q;
  logic [1:0]    dir_q;
  mode_t         mode_q;
  logic [CW-1:0] psc_q, rld_q, cmp_q, pcnt_q, cnt_q, cnt_nxt;
  logic          tick, match, pwm1, lvl;

  wire wr_ctrl = wr_en && wr_addr == A_CTRL;
  wire wr_psc  = wr_en && wr_addr == A_PSC;
  wire wr_rld  = wr_en && wr_addr == A_RLD;
  wire wr_cmp  = wr_en && wr_addr == A_CMP;
  wire wr_ch   = wr_en && wr_addr == A_CH;
  wire wr_req  = wr_en && wr_addr == A_REQ;
  wire wr_stat = wr_en && wr_addr == A_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      down_q  <= 1'b0;
      psc_q   <= '0;
      rld_q   <= '0;
      cmp_q   <= '0;
      dir_q   <= 2'b00;
      mode_q  <= M_FROZEN;
      oen_q   <= 1'b0;
      irqen_q <= 1'b0;
      dmaen_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wr_data[0];
        down_q <= wr_data[1];
      end
      if (wr_psc) psc_q <= wr_data;
      if (wr_rld) rld_q <= wr_data;
      if (wr_cmp) cmp_q <= wr_data;
      if (wr_ch) begin
        mode_q <= mode_t'(wr_data[4:2]);
        oen_q  <= wr_data[5];
        if (!oen_q) dir_q <= wr_data[1:0];
      end
      if (wr_req) begin
        irqen_q <= wr_data[0];
        dmaen_q <= wr_data[1];
      end
    end
  end

  assign tick = run_q && (pcnt_q == psc_q);

  always_comb begin
    cnt_nxt = cnt_q;
    if (tick) begin
      if (down_q) cnt_nxt = (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
      else        cnt_nxt = (cnt_q >= rld_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign match = tick && (cnt_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      pcnt_q <= (!run_q || tick) ? '0 : pcnt_q + 1'b1;
      cnt_q  <= cnt_nxt;
    end
  end

  assign pwm1 = down_q ? (cnt_q <= cmp_q) : (cnt_q < cmp_q);

  always_comb begin
    case (mode_q)
      M_LOW:   lvl = 1'b0;
      M_HIGH:  lvl = 1'b1;
      M_PWM1:  lvl = pwm1;
      M_PWM2:  lvl = !pwm1;
      default: lvl = ocq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocq    <= 1'b0;
      flag_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      case (mode_q)
        M_FROZEN: ocq <= ocq;
        M_SET:    if (match) ocq <= 1'b1;
        M_CLR:    if (match) ocq <= 1'b0;
        M_TGL:    if (match) ocq <= !ocq;
        default:  ocq <= lvl;
      endcase
      if (match)                      flag_q <= 1'b1;
      else if (wr_stat && !wr_data[0]) flag_q <= 1'b0;
      dma_q <= match && dmaen_q;
    end
  end

  assign ocref_o   = lvl;
  assign pin_o     = oen_q && (dir_q == 2'b00) && lvl;
  assign irq_o     = flag_q && irqen_q;
  assign dma_req_o = dma_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[1:0] = {down_q, run_q};
      A_PSC:  rd_data = psc_q;
      A_RLD:  rd_data = rld_q;
      A_CMP:  rd_data = cmp_q;
      A_CH:   rd_data[5:0] = {oen_q, mode_q, dir_q};
      A_REQ:  rd_data[1:0] = {dmaen_q, irqen_q};
      A_STAT: rd_data[0] = flag_q;
      default: rd_data = cnt_q;
    endcase
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R2
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down_q && cnt_q >= rld_q) |=> cnt_q == '0); // R3
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down_q && cnt_q == '0) |=> cnt_q == $past(rld_q)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_stat && !wr_data[0])) |=> flag_q); // R5
  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode_q == M_SET) |=> ocq); // R6
  AST_DIR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    oen_q |=> $stable(dir_q)); // R11
  AST_DMA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> flag_q); // R12

endmodule

// File: tb/timer_oc_channel_tb.sv
module timer_oc_channel_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic ocref_o, pin_o, irq_o, dma_req_o;
  int checks = 0, fails = 0;
  logic exp_oc = 1'b0;

  always #5 clk = ~clk;

  timer_oc_channel #(.CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ocref_o(ocref_o), .pin_o(pin_o),
    .irq_o(irq_o), .dma_req_o(dma_req_o));

  // {mode[2:0], down, cmp[3:0], level per counter value 9..0}
  localparam logic [17:0] VEC [10] = '{
    {3'b110, 1'b0, 4'd4,  10'h00F},
    {3'b110, 1'b1, 4'd4,  10'h01F},
    {3'b111, 1'b0, 4'd4,  10'h3F0},
    {3'b111, 1'b1, 4'd4,  10'h3E0},
    {3'b110, 1'b0, 4'd0,  10'h000},
    {3'b110, 1'b0, 4'd10, 10'h3FF},
    {3'b100, 1'b0, 4'd4,  10'h000},
    {3'b101, 1'b1, 4'd4,  10'h3FF},
    {3'b111, 1'b1, 4'd9,  10'h000},
    {3'b110, 1'b1, 4'd0,  10'h001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic apply(input logic [2:0] m);
    case (m)
      3'd1: exp_oc = 1'b1;
      3'd2: exp_oc = 1'b0;
      3'd3: exp_oc = ~exp_oc;
      default: exp_oc = exp_oc;
    endcase
  endtask

  task automatic run_match(input logic [2:0] m, input int n);
    logic [15:0] c, last;
    logic hit;
    wr(3'd4, {10'd0, 1'b1, m, 2'b00});
    wr(3'd0, 16'h0001);
    rd(3'd7, last);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      #1 c = rd_data;
      hit = (c != last) && (c == 16'd3);
      if (hit) apply(m);
      chk("R6 pin after match", pin_o, exp_oc);
      chk("R12 dma pulse", dma_req_o, hit);
      last = c;
    end
    wr(3'd0, 16'h0000);
    rd(3'd7, c);
    if (c != last && c == 16'd3) apply(m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, c, last;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 ocref", ocref_o, 0);
    chk("R1 pin", pin_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 dma", dma_req_o, 0);

    // table walk: R3 R4 R7 R8 R9 R10
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd9);
    for (int i = 0; i < 10; i++) begin
      logic [17:0] e;
      logic have;
      e = VEC[i];
      wr(3'd0, 16'h0000);
      wr(3'd3, {12'd0, e[13:10]});
      wr(3'd4, {10'd0, 1'b1, e[17:15], 2'b00});
      wr(3'd0, {14'd0, e[14], 1'b1});
      rd_addr = 3'd7;
      have = 1'b0;
      last = '0;
      for (int s = 0; s < 20; s++) begin
        @(negedge clk);
        #1 c = rd_data;
        if (c > 16'd9) chk("R3 counter range", c, 9);
        else chk("R7/R8/R9/R10 level", pin_o, e[c]);
        chk("R7/R8/R9 ocref", ocref_o, pin_o);
        if (have) begin
          if (e[14]) chk("R4 down step", c, (last == 0) ? 16'd9 : last - 1);
          else       chk("R3 up step", c, (last >= 9) ? 16'd0 : last + 1);
        end
        have = 1'b1;
        last = c;
      end
    end

    // match-driven modes: R5 R6 R12
    do_reset();
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd9);
    wr(3'd3, 16'd3);
    wr(3'd5, 16'h0002);
    exp_oc = 1'b0;
    run_match(3'd3, 30);
    run_match(3'd0, 25);
    run_match(3'd2, 20);
    run_match(3'd1, 20);
    rd(3'd6, v);
    chk("R5 flag set", v, 1);
    chk("R12 irq masked", irq_o, 0);
    wr(3'd5, 16'h0003);
    chk("R12 irq enabled", irq_o, 1);
    wr(3'd6, 16'h0001);
    rd(3'd6, v);
    chk("R5 write one keeps flag", v, 1);
    wr(3'd6, 16'h0000);
    rd(3'd6, v);
    chk("R5 clear", v, 0);
    chk("R12 irq cleared", irq_o, 0);

    // prescaler: R2
    do_reset();
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd100);
    wr(3'd0, 16'h0001);
    rd_addr = 3'd7;
    repeat (39) @(negedge clk);
    #1 chk("R2 prescaled count 39", rd_data, 9);
    @(negedge clk);
    #1 chk("R2 prescaled count 40", rd_data, 10);
    wr(3'd0, 16'h0000);
    repeat (8) @(negedge clk);
    #1 chk("R2 stopped hold", rd_data, 10);

    // direction lock: R10 R11
    wr(3'd4, 16'h0034);
    chk("R7 R10 forced high on pin", pin_o, 1);
    wr(3'd4, 16'h0035);
    rd(3'd4, v);
    chk("R11 dir ignored while enabled", v, 16'h0034);
    chk("R11 pin still driven", pin_o, 1);
    wr(3'd4, 16'h0015);
    rd(3'd4, v);
    chk("R11 dir ignored on disabling write", v, 16'h0014);
    chk("R10 pin off when disabled", pin_o, 0);
    wr(3'd4, 16'h0035);
    rd(3'd4, v);
    chk("R11 dir accepted while disabled", v, 16'h0035);
    chk("R10 input dir blocks pin", pin_o, 0);
    chk("R7 ocref forced high", ocref_o, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule